// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block builds the interrupt view of a UART from signals that other logic produces. It takes the live fill counts of the receive and transmit FIFOs and single-cycle event pulses: receive overflow, transmit overflow, framing error, parity error, receive timeout and modem status change. From these it derives a raw status word every cycle. It also keeps a sticky interrupt status register and an interrupt mask, and it drives one level-sensitive interrupt line.

Software reaches the unit over a word-addressed register bus with separate read and write strobes. The mask has no direct write port. One register location sets mask bits and another clears them, and the mask location itself can only be read. Sticky bits are cleared by writing ones to them. The transmit trigger condition sits at bit 13 of the raw status but at bit 10 of the sticky register, so the raw-to-sticky mapping is not one-to-one.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Raw status is combinational from the current inputs. Bit 0 is rx count >= rx trigger. Bit 1 is rx count == 0. Bit 2 is rx count == DEPTH. Bit 3 is tx count == 0. Bit 4 is tx count == DEPTH. Bit 13 is tx count >= tx trigger. All other bits are 0.
- R2: Raw status is read at word 11 (byte 0x2C) and reflects the inputs of the cycle in which it is read. Writes to word 11 have no effect.
- R3: At each clock edge, each raw status bit 0 to 4 that is set is ORed into the same bit of the sticky register (word 5, byte 0x14).
- R4: Raw status bit 13 sets sticky bit 10. Sticky bit 13 does not exist and always reads 0.
- R5: Event pulses set sticky bits as follows: rx overflow sets bit 5, framing error sets bit 6, parity error sets bit 7, rx timeout sets bit 8, modem change sets bit 9 and tx overflow sets bit 12. Sticky bit 11 is never set.
- R6: A write to word 2 (byte 0x08) ORs wdata[12:0] into the 13-bit mask.
- R7: A write to word 3 (byte 0x0C) clears the mask bits where wdata has ones.
- R8: The mask reads back at word 4 (byte 0x10). Writes to word 4 leave the mask unchanged.
- R9: A write to word 5 clears the sticky bits where wdata has ones. Other sticky bits hold.
- R10: If a set condition for a sticky bit is true in the same cycle as a clear write to that bit, the bit stays set.
- R11: irq_o is high exactly when (mask AND sticky) is non-zero.
- R12: Reset clears the mask and the sticky register. Reset loads both trigger levels with 32.
- R13: The rx trigger level (word 8, byte 0x20) and the tx trigger level (word 17, byte 0x44) are written from wdata[CNT_W-1:0] and read back zero-extended. Unmapped words read 0. rdata_o is 0 when rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| tx_cnt_i | input | CNT_W | Transmit FIFO fill count |
| rx_ovr_i | input | 1 | Receive overflow pulse |
| tx_ovr_i | input | 1 | Transmit overflow pulse |
| frame_err_i | input | 1 | Framing error pulse |
| par_err_i | input | 1 | Parity error pulse |
| rx_tout_i | input | 1 | Receive timeout pulse |
| modem_i | input | 1 | Modem status change pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The two functions that can land in the same cycle are a write-one-to-clear on the sticky register and a set from a live status condition or an event pulse. The bench provokes this in two ways. It clears the rx-empty bit while the rx count is still zero. It also pulses parity error in the same cycle as a clear write to bit 7. A behavioural model applies the set after the clear, and every clock the bench compares the sticky read-back and irq_o against that model. The bench also clears bits after their conditions have gone away, to show that the clear works once the set is inactive.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_AW = 5;
  localparam int IRQ_W  = 13;
  localparam int RAW_W  = 14;

  localparam logic [REG_AW-1:0] A_IEN   = 5'd2;
  localparam logic [REG_AW-1:0] A_IDIS  = 5'd3;
  localparam logic [REG_AW-1:0] A_IMASK = 5'd4;
  localparam logic [REG_AW-1:0] A_ISTS  = 5'd5;
  localparam logic [REG_AW-1:0] A_RXTRG = 5'd8;
  localparam logic [REG_AW-1:0] A_RAW   = 5'd11;
  localparam logic [REG_AW-1:0] A_TXTRG = 5'd17;

  localparam int RAW_TXTRG = 13;
  localparam int STK_TXTRG = 10;
  localparam int STK_RXOVR = 5;
  localparam int STK_FRAME = 6;
  localparam int STK_PAR   = 7;
  localparam int STK_TOUT  = 8;
  localparam int STK_MODEM = 9;
  localparam int STK_TXOVR = 12;

  typedef struct packed {
    logic rx_ovr;
    logic tx_ovr;
    logic frame;
    logic parity;
    logic tout;
    logic modem;
  } evt_t;
endpackage

// File: rtl/uart_irq_raw.sv
module uart_irq_raw
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_trg_i,
  input  logic [CNT_W-1:0] tx_trg_i,
  output logic [RAW_W-1:0] raw_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  always_comb begin
    raw_o            = '0;
    raw_o[0]         = rx_cnt_i >= rx_trg_i;
    raw_o[1]         = rx_cnt_i == '0;
    raw_o[2]         = rx_cnt_i == FULL;
    raw_o[3]         = tx_cnt_i == '0;
    raw_o[4]         = tx_cnt_i == FULL;
    raw_o[RAW_TXTRG] = tx_cnt_i >= tx_trg_i;
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sts_o[b] <= 1'b0;
      else if (set_i[b])  sts_o[b] <= 1'b1;  // set wins over clear
      else if (clr_i[b])  sts_o[b] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> sts_o[b]);  // R10
    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_o[b] && !clr_i[b] |=> sts_o[b]);  // R9
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         dis_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_o <= '0;
    else if (en_we_i)  mask_o <= mask_o | wdata_i;
    else if (dis_we_i) mask_o <= mask_o & ~wdata_i;
  end

  AST_EN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (mask_o & $past(wdata_i)) == $past(wdata_i));  // R6
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_we_i && !en_we_i |=> (mask_o & $past(wdata_i)) == '0);  // R7
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int CNT_W    = $clog2(DEPTH) + 1,
  parameter int TRIG_RST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic              rx_ovr_i,
  input  logic              tx_ovr_i,
  input  logic              frame_err_i,
  input  logic              par_err_i,
  input  logic              rx_tout_i,
  input  logic              modem_i,
  output logic              irq_o
);
  logic [CNT_W-1:0] rx_trg_q, tx_trg_q;
  logic [RAW_W-1:0] raw;
  logic [IRQ_W-1:0] set_vec, clr_vec, sts, mask;
  evt_t             evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_trg_q <= CNT_W'(TRIG_RST);
      tx_trg_q <= CNT_W'(TRIG_RST);
    end else if (wr_i) begin
      if (addr_i == A_RXTRG) rx_trg_q <= wdata_i[CNT_W-1:0];
      if (addr_i == A_TXTRG) tx_trg_q <= wdata_i[CNT_W-1:0];
    end
  end

  uart_irq_raw #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_raw (
    .rx_cnt_i (rx_cnt_i),
    .tx_cnt_i (tx_cnt_i),
    .rx_trg_i (rx_trg_q),
    .tx_trg_i (tx_trg_q),
    .raw_o    (raw)
  );

  assign evt = '{rx_ovr: rx_ovr_i, tx_ovr: tx_ovr_i, frame: frame_err_i,
                 parity: par_err_i, tout: rx_tout_i, modem: modem_i};

  always_comb begin
    set_vec            = '0;
    set_vec[4:0]       = raw[4:0];
    set_vec[STK_TXTRG] = raw[RAW_TXTRG];
    set_vec[STK_RXOVR] = evt.rx_ovr;
    set_vec[STK_FRAME] = evt.frame;
    set_vec[STK_PAR]   = evt.parity;
    set_vec[STK_TOUT]  = evt.tout;
    set_vec[STK_MODEM] = evt.modem;
    set_vec[STK_TXOVR] = evt.tx_ovr;
  end

  assign clr_vec = (wr_i && addr_i == A_ISTS) ? wdata_i[IRQ_W-1:0] : '0;

  uart_irq_sticky #(.W(IRQ_W)) i_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .sts_o  (sts)
  );

  uart_irq_mask #(.W(IRQ_W)) i_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_we_i  (wr_i && addr_i == A_IEN),
    .dis_we_i (wr_i && addr_i == A_IDIS),
    .wdata_i  (wdata_i[IRQ_W-1:0]),
    .mask_o   (mask)
  );

  assign irq_o = |(mask & sts);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_IMASK: rdata_o = 32'(mask);
        A_ISTS:  rdata_o = 32'(sts);
        A_RXTRG: rdata_o = 32'(rx_trg_q);
        A_TXTRG: rdata_o = 32'(tx_trg_q);
        A_RAW:   rdata_o = 32'(raw);
        default: rdata_o = '0;
      endcase
    end
  end

  AST_MASK_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == A_IMASK |=> $stable(mask));  // R8
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask == '0 |-> !irq_o);  // R11
  AST_NO_STK11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts[11]);  // R5
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic wr = 0, rd = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [CW-1:0] rx_cnt = '0, tx_cnt = '0;
  logic rx_ovr = 0, tx_ovr = 0, frame = 0, par = 0, tout = 0, modem = 0;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl #(.DEPTH(DEPTH)) i_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
    .rx_ovr_i(rx_ovr), .tx_ovr_i(tx_ovr), .frame_err_i(frame),
    .par_err_i(par), .rx_tout_i(tout), .modem_i(modem), .irq_o(irq));

  // behavioural reference model
  logic [12:0] m_mask = '0, m_sts = '0;
  int m_rt = 32, m_tt = 32;

  function automatic logic [13:0] raw_f(int rx, int tx, int rt, int tt);
    logic [13:0] r = '0;
    r[0] = rx >= rt;
    r[1] = rx == 0;
    r[2] = rx == DEPTH;
    r[3] = tx == 0;
    r[4] = tx == DEPTH;
    r[13] = tx >= tt;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= '0; m_sts <= '0; m_rt <= 32; m_tt <= 32;
    end else begin
      logic [13:0] r;
      logic [12:0] s, c;
      r = raw_f(int'(rx_cnt), int'(tx_cnt), m_rt, m_tt);
      s = '0;
      s[4:0] = r[4:0]; s[10] = r[13];
      s[5] = rx_ovr; s[6] = frame; s[7] = par; s[8] = tout; s[9] = modem;
      s[12] = tx_ovr;
      c = (wr && addr == 5) ? wdata[12:0] : '0;
      m_sts <= (m_sts & ~c) | s;
      if (wr && addr == 2) m_mask <= m_mask | wdata[12:0];
      if (wr && addr == 3) m_mask <= m_mask & ~wdata[12:0];
      if (wr && addr == 8) m_rt <= int'(wdata[CW-1:0]);
      if (wr && addr == 17) m_tt <= int'(wdata[CW-1:0]);
    end
  end

  function automatic logic [31:0] exp_rd();
    if (!rd) return '0;
    case (addr)
      4: return 32'(m_mask);
      5: return 32'(m_sts);
      8: return 32'(m_rt);
      17: return 32'(m_tt);
      11: return 32'(raw_f(int'(rx_cnt), int'(tx_cnt), m_rt, m_tt));
      default: return '0;
    endcase
  endfunction

  function automatic string req_of();
    if (!rst_n) return "R12";
    case (addr)
      4: return "R6";
      5: return "R3";
      11: return "R1";
      8, 17: return "R13";
      default: return "R13";
    endcase
  endfunction

  always @(negedge clk) if (!done) begin
    logic [31:0] e;
    e = exp_rd();
    n_cmp++;
    if (rdata !== e) begin
      n_bad++;
      $display("FAIL %s rdata addr %0d: got %h exp %h", req_of(), addr, rdata, e);
    end
    n_cmp++;
    if (irq !== ((m_mask & m_sts) != 0)) begin
      n_bad++;
      $display("FAIL R11 irq: got %b exp %b", irq, (m_mask & m_sts) != 0);
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr = 0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [4:0] a);
    @(posedge clk); #1; rd = 1; addr = a;
    @(posedge clk); #1; rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    // R12: reset values
    rd_reg(8); rd_reg(17); rd_reg(4); rd_reg(5);
    @(posedge clk); #1; rst_n = 1;
    idle(2);
    rd_reg(5);                      // R3: empty bits latched
    rd_reg(11);                     // R1, R2
    wr_reg(11, 32'hFFFF_FFFF);      // R2: write ignored
    rd_reg(11);
    // R10: clear rx-empty while still empty
    wr_reg(5, 32'h0000_0002); rd_reg(5);
    rx_cnt = 5;
    wr_reg(5, 32'h0000_1FFF); rd_reg(5);  // R9
    rx_cnt = 32; idle(1); rd_reg(11); rd_reg(5);
    rx_cnt = 64; tx_cnt = 64; idle(1); rd_reg(11); rd_reg(5);  // R4: bit10
    tx_cnt = 10; rx_cnt = 10;
    wr_reg(5, 32'hFFFF_FFFF); rd_reg(5);
    // R5: events one by one
    @(posedge clk); #1; rx_ovr = 1; @(posedge clk); #1; rx_ovr = 0; rd_reg(5);
    @(posedge clk); #1; frame = 1;  @(posedge clk); #1; frame = 0; rd_reg(5);
    @(posedge clk); #1; tout = 1;   @(posedge clk); #1; tout = 0;
    @(posedge clk); #1; modem = 1;  @(posedge clk); #1; modem = 0;
    @(posedge clk); #1; tx_ovr = 1; @(posedge clk); #1; tx_ovr = 0; rd_reg(5);
    wr_reg(5, 32'hFFFF_FFFF); rd_reg(5);
    // R10: parity pulse with clear of bit7
    @(posedge clk); #1; par = 1; wr = 1; addr = 5; wdata = 32'h80;
    @(posedge clk); #1; par = 0; wr = 0; wdata = '0; rd_reg(5);
    // R6, R7, R8, R11
    wr_reg(2, 32'h0000_0080); rd_reg(4); idle(1);
    wr_reg(4, 32'h0000_0000); rd_reg(4);  // R8
    wr_reg(2, 32'hFFFF_F000); rd_reg(4);
    wr_reg(3, 32'h0000_0080); rd_reg(4); idle(1);  // R7
    wr_reg(5, 32'h0000_1000); idle(1);
    @(posedge clk); #1; tx_ovr = 1; @(posedge clk); #1; tx_ovr = 0; idle(2);
    wr_reg(3, 32'hFFFF_FFFF); rd_reg(4);
    // R13: trigger levels
    wr_reg(8, 32'h0000_0003); wr_reg(17, 32'h0000_0040);
    rd_reg(8); rd_reg(17);
    rx_cnt = 3; tx_cnt = 63; idle(1); rd_reg(11);
    rx_cnt = 2; tx_cnt = 64; idle(1); rd_reg(11);
    rd_reg(1); rd_reg(31);
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule